// File: doc/BRIEF.md
# Full-Bridge Diagonal Drive Sequencer

This block produces the four gate commands of a full bridge: a low and a high switch on leg A, and a low and a high switch on leg B. A triangle counter takes the place of a timing-capacitor ramp. The counter climbs from zero to one third of full scale and then moves back and forth between one third and two thirds. Each time it turns, the diagonal pair that is conducting (low A with high B, or low B with high A) switches off at once. The opposite diagonal switches on only after a dead time that can be selected.

Two comparator-style supply flags provide undervoltage lockout with hysteresis. At start-up both low sides are driven high so that the bootstrap supplies charge before the first high-side pulse. A non-latched hold input stops the oscillation with both low sides on. A latched fault input turns every gate off until the supply has gone through a full power cycle.

Top module: `bridge_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after `supplyBelowOff` is sampled high in any mode, all four gate outputs are low.
- R2: From lockout, only a sampled `supplyAboveOn` starts operation. While both supply flags are low, the current mode continues unchanged, whether that mode is running or locked out.
- R3: In the cycle after start-up, `lowA` and `lowB` are high and `highA` and `highB` are low. This precharge pattern lasts exactly LOW_TH cycles, because the ramp restarts from zero.
- R4: After precharge, all gates are low for one dead time. Then `lowA` and `highB` are high for HALF−dead cycles, where HALF = HIGH_TH − LOW_TH.
- R5: The sequence continues with one dead time with all gates low, then `lowB` and `highA` for HALF−dead cycles, then one dead time, then `lowA` and `highB` again. One full period is 2·HALF cycles.
- R6: With `deadShort` = 0 a dead gap is DEAD_LONG cycles. With `deadShort` = 1 it is DEAD_LONG/2 cycles. The input is sampled when each gap begins.
- R7: In the cycle after `holdReq` is sampled high, `lowA` and `lowB` are high and both high sides are low, and this stays so while the hold lasts. When the hold is released, the ramp restarts from zero and the R3 precharge follows.
- R8: In the cycle after `faultIn` is sampled high, all gates are low. They stay low after the fault clears and whatever `holdReq` does. Only `supplyBelowOff` followed by `supplyAboveOn` restarts the sequence.
- R9: Lockout has priority over fault, and fault has priority over hold. A fault that arrives together with lockout is not latched, and a fault together with a hold gives all-low outputs, not the hold pattern.
- R10: The two gates of one leg (`lowA` with `highA`, `lowB` with `highB`) are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supplyAboveOn | input | 1 | Supply is above the turn-on threshold |
| supplyBelowOff | input | 1 | Supply is below the turn-off threshold |
| holdReq | input | 1 | Non-latched hold (ramp forced low) |
| faultIn | input | 1 | Latched shutdown request |
| deadShort | input | 1 | Selects the half-length dead time |
| lowA | output | 1 | Leg A low-side gate |
| highA | output | 1 | Leg A high-side gate |
| lowB | output | 1 | Leg B low-side gate |
| highB | output | 1 | Leg B high-side gate |

## Verification
Every gate output is registered from the next mode, so a wrong mode shows at the pins in the very next cycle as a wrong pattern. A ramp count that is off by one cannot be seen at once. It shows only at the next turning point, as a drive phase or precharge that is one cycle longer or shorter than expected, which can be up to HALF cycles later. A dead counter loaded with the wrong length shows as a gap of the wrong length when the next gap comes. A fault latch that clears too early shows as activity on the gates before a supply power cycle has happened.

// File: rtl/bridge_seq_pkg.sv
package bridge_seq_pkg;

  typedef enum logic [2:0] {
    ST_LOCKOUT,
    ST_PRECHARGE,
    ST_DEAD_A,
    ST_DRIVE_A,
    ST_DEAD_B,
    ST_DRIVE_B,
    ST_HOLD,
    ST_FAULT
  } seqState_t;

  // gate vector order: {lowA, highA, lowB, highB}
  localparam logic [3:0] GATE_OFF = 4'b0000;
  localparam logic [3:0] GATE_PRE = 4'b1010;
  localparam logic [3:0] GATE_A   = 4'b1001;
  localparam logic [3:0] GATE_B   = 4'b0110;

  typedef struct packed {
    logic       rampClear;
    logic       rampUp;
    logic       rampDown;
    logic       deadLoad;
    logic [3:0] gateNext;
  } seqStrobe_t;

  typedef struct packed {
    logic hitLowRise;
    logic hitHighRise;
    logic hitLowFall;
    logic deadDone;
  } rampFlags_t;

  function automatic logic [3:0] gatesFor(seqState_t s);
    case (s)
      ST_PRECHARGE, ST_HOLD: gatesFor = GATE_PRE;
      ST_DRIVE_A:            gatesFor = GATE_A;
      ST_DRIVE_B:            gatesFor = GATE_B;
      default:               gatesFor = GATE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/bridge_seq_dp.sv
module bridge_seq_dp
  import bridge_seq_pkg::*;
#(
  parameter int RAMP_FULL = 48,
  parameter int LOW_TH    = 16,
  parameter int HIGH_TH   = 32,
  parameter int DEAD_LONG = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       deadShort,
  input  seqStrobe_t strobe,
  output rampFlags_t flags,
  output logic [3:0] gates
);

  localparam int RAMP_W     = $clog2(RAMP_FULL + 1);
  localparam int DEAD_W     = $clog2(DEAD_LONG + 1);
  localparam int DEAD_SHORT = DEAD_LONG / 2;

  localparam logic [RAMP_W-1:0] LOW_RISE  = RAMP_W'(LOW_TH - 1);
  localparam logic [RAMP_W-1:0] HIGH_RISE = RAMP_W'(HIGH_TH - 1);
  localparam logic [RAMP_W-1:0] LOW_FALL  = RAMP_W'(LOW_TH + 1);
  localparam logic [DEAD_W-1:0] LONG_M1   = DEAD_W'(DEAD_LONG - 1);
  localparam logic [DEAD_W-1:0] SHORT_M1  = DEAD_W'(DEAD_SHORT - 1);

  logic [RAMP_W-1:0] rampCnt;
  logic [DEAD_W-1:0] deadCnt;
  logic [3:0]        gateReg;

  // triangle ramp standing in for the timing capacitor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rampCnt <= '0;
    else if (strobe.rampClear) rampCnt <= '0;
    else if (strobe.rampUp)    rampCnt <= rampCnt + 1'b1;
    else if (strobe.rampDown)  rampCnt <= rampCnt - 1'b1;
  end

  // dead-time down counter, length chosen when a gap starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              deadCnt <= '0;
    else if (strobe.deadLoad) deadCnt <= deadShort ? SHORT_M1 : LONG_M1;
    else if (deadCnt != '0)   deadCnt <= deadCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gateReg <= GATE_OFF;
    else        gateReg <= strobe.gateNext;
  end

  always_comb begin
    flags.hitLowRise  = (rampCnt == LOW_RISE);
    flags.hitHighRise = (rampCnt == HIGH_RISE);
    flags.hitLowFall  = (rampCnt == LOW_FALL);
    flags.deadDone    = (deadCnt == '0);
  end

  assign gates = gateReg;

endmodule

// File: rtl/bridge_seq_ctrl.sv
module bridge_seq_ctrl
  import bridge_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supplyAboveOn,
  input  logic       supplyBelowOff,
  input  logic       holdReq,
  input  logic       faultIn,
  input  rampFlags_t flags,
  output seqStrobe_t strobe
);

  seqState_t stCur;
  seqState_t stNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stCur <= ST_LOCKOUT;
    else        stCur <= stNext;
  end

  always_comb begin
    stNext = stCur;
    if (supplyBelowOff) begin
      stNext = ST_LOCKOUT;
    end else begin
      case (stCur)
        ST_LOCKOUT: begin
          if (supplyAboveOn) begin
            if (faultIn)      stNext = ST_FAULT;
            else if (holdReq) stNext = ST_HOLD;
            else              stNext = ST_PRECHARGE;
          end
        end
        ST_FAULT: stNext = ST_FAULT;
        default: begin
          if (faultIn)      stNext = ST_FAULT;
          else if (holdReq) stNext = ST_HOLD;
          else begin
            case (stCur)
              ST_HOLD:      stNext = ST_PRECHARGE;
              ST_PRECHARGE: if (flags.hitLowRise)  stNext = ST_DEAD_A;
              ST_DEAD_A:    if (flags.deadDone)    stNext = ST_DRIVE_A;
              ST_DRIVE_A:   if (flags.hitHighRise) stNext = ST_DEAD_B;
              ST_DEAD_B:    if (flags.deadDone)    stNext = ST_DRIVE_B;
              ST_DRIVE_B:   if (flags.hitLowFall)  stNext = ST_DEAD_A;
              default:      stNext = stCur;
            endcase
          end
        end
      endcase
    end
  end

  logic rampRising;
  logic rampFalling;

  always_comb begin
    rampRising  = (stCur == ST_PRECHARGE) || (stCur == ST_DEAD_A) || (stCur == ST_DRIVE_A);
    rampFalling = (stCur == ST_DEAD_B) || (stCur == ST_DRIVE_B);

    strobe.rampClear = (stNext == ST_LOCKOUT) || (stNext == ST_HOLD) || (stNext == ST_FAULT) ||
                       ((stNext == ST_PRECHARGE) && (stCur != ST_PRECHARGE));
    strobe.rampUp    = !strobe.rampClear && rampRising;
    strobe.rampDown  = !strobe.rampClear && rampFalling;
    strobe.deadLoad  = ((stNext == ST_DEAD_A) || (stNext == ST_DEAD_B)) && (stNext != stCur);
    strobe.gateNext  = gatesFor(stNext);
  end

endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
  import bridge_seq_pkg::*;
#(
  parameter int RAMP_FULL = 48,
  parameter int LOW_TH    = RAMP_FULL / 3,
  parameter int HIGH_TH   = (2 * RAMP_FULL) / 3,
  parameter int DEAD_LONG = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supplyAboveOn,
  input  logic supplyBelowOff,
  input  logic holdReq,
  input  logic faultIn,
  input  logic deadShort,
  output logic lowA,
  output logic highA,
  output logic lowB,
  output logic highB
);

  seqStrobe_t strobe;
  rampFlags_t flags;
  logic [3:0] gates;

  bridge_seq_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .supplyAboveOn  (supplyAboveOn),
    .supplyBelowOff (supplyBelowOff),
    .holdReq        (holdReq),
    .faultIn        (faultIn),
    .flags          (flags),
    .strobe         (strobe)
  );

  bridge_seq_dp #(
    .RAMP_FULL (RAMP_FULL),
    .LOW_TH    (LOW_TH),
    .HIGH_TH   (HIGH_TH),
    .DEAD_LONG (DEAD_LONG)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .deadShort (deadShort),
    .strobe    (strobe),
    .flags     (flags),
    .gates     (gates)
  );

  assign {lowA, highA, lowB, highB} = gates;

endmodule

// File: rtl/bridge_seq_chk.sv
module bridge_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic supplyBelowOff,
  input logic holdReq,
  input logic faultIn,
  input logic lowA,
  input logic highA,
  input logic lowB,
  input logic highB
);

  p_lockout_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    supplyBelowOff |=> !lowA && !highA && !lowB && !highB);

  p_fault_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    faultIn |=> !lowA && !highA && !lowB && !highB);

  p_hold_high_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    holdReq |=> !highA && !highB);

  p_leg_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(lowA && highA) && !(lowB && highB));

  p_gap_after_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lowA && highB) |=> !highA);

  p_gap_after_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lowB && highA) |=> !highB);

  p_precharge_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lowA && lowB) |=> !highA && !highB);

endmodule

bind bridge_seq bridge_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .supplyBelowOff (supplyBelowOff),
  .holdReq        (holdReq),
  .faultIn        (faultIn),
  .lowA           (lowA),
  .highA          (highA),
  .lowB           (lowB),
  .highB          (highB)
);

// File: tb/bridge_seq_bench.sv
module bridge_seq_bench;

  localparam int FULL   = 48;
  localparam int LOW    = 16;
  localparam int HIGH   = 32;
  localparam int DLONG  = 8;
  localparam int DSHORT = DLONG / 2;
  localparam int HALF   = HIGH - LOW;
  localparam int PERIOD = 2 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supplyAboveOn = 1'b0;
  logic supplyBelowOff = 1'b0;
  logic holdReq = 1'b0;
  logic faultIn = 1'b0;
  logic deadShort = 1'b0;
  logic lowA, highA, lowB, highB;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bridge_seq #(
    .RAMP_FULL (FULL),
    .LOW_TH    (LOW),
    .HIGH_TH   (HIGH),
    .DEAD_LONG (DLONG)
  ) u_bridge_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .supplyAboveOn  (supplyAboveOn),
    .supplyBelowOff (supplyBelowOff),
    .holdReq        (holdReq),
    .faultIn        (faultIn),
    .deadShort      (deadShort),
    .lowA           (lowA),
    .highA          (highA),
    .lowB           (lowB),
    .highB          (highB)
  );

  function automatic logic [3:0] gatesNow();
    return {lowA, highA, lowB, highB};
  endfunction

  // expected pattern i cycles after start: precharge, then the diagonal cycle
  function automatic logic [3:0] expWave(int i, int d);
    int k;
    if (i < LOW) return 4'b1010;
    k = (i - LOW) % PERIOD;
    if (k < d)        return 4'b0000;
    if (k < HALF)     return 4'b1001;
    if (k < HALF + d) return 4'b0000;
    return 4'b0110;
  endfunction

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp_);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp_, $time);
    end
  endtask

  task automatic runWave(input string req, input int d, input int start, input int n);
    int mism = 0;
    int legBad = 0;
    logic [3:0] firstAct = '0;
    logic [3:0] firstExp = '0;
    logic [3:0] legAct = '0;
    for (int i = 0; i < n; i++) begin
      logic [3:0] g;
      logic [3:0] e;
      @(negedge clk);
      g = gatesNow();
      e = expWave(start + i, d);
      if (g !== e) begin
        if (mism == 0) begin firstAct = g; firstExp = e; end
        mism++;
      end
      if ((g[3] & g[2]) | (g[1] & g[0])) begin
        legBad++;
        legAct = g;
      end
    end
    check(mism == 0, req, firstAct, firstExp);
    check(legBad == 0, "R10", legAct, 4'b0000);
  endtask

  task automatic expectFor(input string req, input int n, input logic [3:0] exp_);
    int mism = 0;
    logic [3:0] firstAct = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gatesNow() !== exp_) begin
        if (mism == 0) firstAct = gatesNow();
        mism++;
      end
    end
    check(mism == 0, req, firstAct, exp_);
  endtask

  task automatic powerCycle();
    supplyAboveOn = 1'b0;
    supplyBelowOff = 1'b1;
    @(negedge clk);
    @(negedge clk);
    supplyBelowOff = 1'b0;
    @(negedge clk);
    supplyAboveOn = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(gatesNow() === 4'b0000, "R1", gatesNow(), 4'b0000);
    rst_n = 1'b1;
    expectFor("R2", 20, 4'b0000);
  endtask

  task automatic t_startLong();
    deadShort = 1'b0;
    supplyAboveOn = 1'b1;
    runWave("R3", DLONG, 0, LOW);
    runWave("R4", DLONG, LOW, HALF);
    runWave("R5", DLONG, LOW + HALF, 2 * PERIOD);
  endtask

  task automatic t_hysteresis();
    supplyAboveOn = 1'b0;
    runWave("R2", DLONG, LOW + HALF + 2 * PERIOD, PERIOD);
    supplyBelowOff = 1'b1;
    expectFor("R1", 5, 4'b0000);
    supplyBelowOff = 1'b0;
    expectFor("R2", 10, 4'b0000);
    supplyAboveOn = 1'b1;
    runWave("R3", DLONG, 0, LOW + PERIOD);
  endtask

  task automatic t_shortDead();
    deadShort = 1'b1;
    powerCycle();
    runWave("R6", DSHORT, 0, LOW + 2 * PERIOD);
    deadShort = 1'b0;
    powerCycle();
    runWave("R6", DLONG, 0, LOW + PERIOD);
  endtask

  task automatic t_hold();
    powerCycle();
    runWave("R7", DLONG, 0, LOW + DLONG + 2);
    holdReq = 1'b1;
    expectFor("R7", 12, 4'b1010);
    holdReq = 1'b0;
    runWave("R7", DLONG, 0, LOW + PERIOD);
  endtask

  task automatic t_fault();
    powerCycle();
    runWave("R8", DLONG, 0, LOW + HALF + 3);
    faultIn = 1'b1;
    @(negedge clk);
    check(gatesNow() === 4'b0000, "R8", gatesNow(), 4'b0000);
    faultIn = 1'b0;
    expectFor("R8", 40, 4'b0000);
    holdReq = 1'b1;
    expectFor("R8", 5, 4'b0000);
    holdReq = 1'b0;
    expectFor("R8", 10, 4'b0000);
    powerCycle();
    runWave("R8", DLONG, 0, LOW + HALF);
  endtask

  task automatic t_priority();
    faultIn = 1'b1;
    holdReq = 1'b1;
    expectFor("R9", 5, 4'b0000);
    faultIn = 1'b0;
    holdReq = 1'b0;
    expectFor("R9", 5, 4'b0000);
    supplyAboveOn = 1'b0;
    supplyBelowOff = 1'b1;
    faultIn = 1'b1;
    expectFor("R9", 3, 4'b0000);
    faultIn = 1'b0;
    supplyBelowOff = 1'b0;
    @(negedge clk);
    supplyAboveOn = 1'b1;
    runWave("R9", DLONG, 0, LOW + HALF);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_startLong();
    t_hysteresis();
    t_shortDead();
    t_hold();
    t_fault();
    t_priority();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule